// File: doc/BRIEF.md
# Single-Lane SPI Flash Command Engine

This block runs one whole serial-flash transaction on its own from a shared 128-byte buffer. Software first places the opcode, address, dummy and write-payload bytes at the start of the buffer. It then sets how many bytes to send and how many to receive, and starts the engine with one control write. The engine shifts the outgoing bytes out on a single data line in SPI mode 0 (clock idles low, data captured on the rising clock edge). It then collects the requested reply bytes and stores each one in the buffer right after the last outgoing byte. Chip-select stays low for the whole transfer.

Completion is reported in two steps. A ready flag is raised while the engine is still marked as running, and the running flag drops one cycle later. Software finishes the sequence by writing zero to the control register. After each transfer a programmable count of quiet cycles must pass before a new start is accepted. A soft-reset bit returns the sequencer to idle at once. Each serial bit takes two core clock cycles, low half first and high half second. There is no divider.

Register offsets on the 12-bit register bus: control 0x500, send count 0x504, receive count 0x508, miscellaneous 0x538, state 0x550, buffer 0x800–0x87F. The buffer is reached as 32-bit little-endian words.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, the control, count, miscellaneous and state registers read 0, and the chip-select line is high while the clock and data-out lines are low.
- R2: Buffer word k (address 0x800+4k) holds byte 4k in bits 7:0 up to byte 4k+3 in bits 31:24. A written word reads back unchanged.
- R3: A control write with bit 3 (enable) and bit 2 (start) both set is accepted only when the engine is idle and the quiet gap has expired. In the cycle after the accepting edge, chip-select goes low and stays low for exactly 16×N cycles, where N is the total byte count. Each bit is two cycles: the clock is low in the first and high in the second.
- R4: Outgoing bytes leave in buffer order starting at byte 0, most significant bit first. The data-out line is low during the receive bytes and while idle.
- R5: The data-in line is sampled at the end of each clock-high half, most significant bit first. Received byte m is written to buffer byte S+m, where S is the effective send count, and buffer bytes below S are left unchanged.
- R6: Completion takes two steps. When chip-select rises, ready (control bit 1) is 1 while running (control bit 0) is still 1 for one cycle. Running then clears, and ready stays set until a control write with bit 3 clear or the next accepted start.
- R7: A start request made while running, or while the quiet gap is still counting, is ignored: chip-select stays as the running transfer or the idle state dictates.
- R8: After running clears, a start is refused for the number of cycles held in miscellaneous bits 4:0. After that the start is accepted.
- R9: The total byte count is limited to 128 and the send count to 128. Receive bytes beyond the end of the buffer are dropped and never written over byte 0.
- R10: Writing 1 to miscellaneous bit 28 returns the engine to idle at the next edge. Chip-select goes high, running and ready read 0, and the state reads 0. Bit 28 always reads 0.
- R11: The control register reads running in bit 0, ready in bit 1, enable in bit 3. Bits 2 and 4 always read 0.
- R12: The state register bits 3:0 read 0 when idle, 2 while shifting and 3 in the completion cycle.
- R13: Miscellaneous bits 26:25, 9:8 and 4:0 read back as written. A zero-length transfer (both counts 0) sets ready without lowering chip-select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; one serial bit spans two cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | Write qualifier for reg_en |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Active-low chip-select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
An accepted start is visible right after the accepting edge. Chip-select is low from that cycle for 16×N cycles. The serial clock rises in every odd cycle of that window. Ready appears in the cycle after the window with running still set, and running drops one cycle later. Soft reset and rejected starts show up at the very next edge. The bench keeps a behavioural model that advances at each rising edge and compares chip-select, clock and data-out at each falling edge. Register reads and buffer contents are sampled one nanosecond after a falling edge, so every value has settled since the last rising edge.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  localparam int ADDR_W = 12;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 12'h500;
  localparam logic [ADDR_W-1:0] OFS_TXN  = 12'h504;
  localparam logic [ADDR_W-1:0] OFS_RXN  = 12'h508;
  localparam logic [ADDR_W-1:0] OFS_MISC = 12'h538;
  localparam logic [ADDR_W-1:0] OFS_STAT = 12'h550;
  localparam logic [ADDR_W-1:0] OFS_BUF  = 12'h800;

  localparam int CTRL_BUSY  = 0;
  localparam int CTRL_RDY   = 1;
  localparam int CTRL_GO    = 2;
  localparam int CTRL_EN    = 3;
  localparam int MISC_SRST  = 28;
  localparam int MISC_FLAT  = 25;
  localparam int MISC_CLAT  = 8;

  typedef enum logic [3:0] {
    ST_IDLE   = 4'd0,
    ST_SHIFT  = 4'd2,
    ST_FINISH = 4'd3
  } eng_state_e;
endpackage

// File: rtl/spi_eng_buf.sv
module spi_eng_buf #(
  parameter int BUF_BYTES = 128,
  localparam int IDX_W  = $clog2(BUF_BYTES),
  localparam int WORDS  = BUF_BYTES / 4,
  localparam int WIDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              host_we,
  input  logic [WIDX_W-1:0] host_widx,
  input  logic [31:0]       host_wdata,
  input  logic [WIDX_W-1:0] host_ridx,
  output logic [31:0]       host_rdata,
  input  logic              eng_we,
  input  logic [IDX_W-1:0]  eng_idx,
  input  logic [7:0]        eng_wbyte,
  output logic [7:0]        eng_rbyte
);
  logic [31:0] mem [WORDS];
  logic [31:0] eng_word;

  // storage array: no reset, engine byte write wins over a host word write
  always_ff @(posedge clk) begin
    for (int w = 0; w < WORDS; w++) begin
      if (eng_we && (eng_idx[IDX_W-1:2] == WIDX_W'(w)))
        mem[w][8*eng_idx[1:0] +: 8] <= eng_wbyte;
      else if (host_we && (host_widx == WIDX_W'(w)))
        mem[w] <= host_wdata;
    end
  end

  always_comb begin
    host_rdata = mem[host_ridx];
    eng_word   = mem[eng_idx[IDX_W-1:2]];
    eng_rbyte  = eng_word[8*eng_idx[1:0] +: 8];
  end
endmodule

// File: rtl/spi_eng_regs.sv
module spi_eng_regs
  import spi_eng_pkg::*;
#(
  parameter int BUF_BYTES = 128,
  parameter int GAP_W = 5,
  localparam int IDX_W  = $clog2(BUF_BYTES),
  localparam int CNT_W  = IDX_W + 1,
  localparam int WIDX_W = IDX_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [CNT_W-1:0]  tx_cnt,
  output logic [CNT_W-1:0]  rx_cnt,
  output logic [GAP_W-1:0]  gap_len,
  output logic              start_req,
  output logic              rdy_clr,
  output logic              soft_rst,
  input  logic              busy,
  input  logic              ready,
  input  eng_state_e        state,
  output logic              host_we,
  output logic [WIDX_W-1:0] host_widx,
  output logic [WIDX_W-1:0] host_ridx,
  input  logic [31:0]       host_rdata
);
  logic             en_q, en_n;
  logic [CNT_W-1:0] tx_q, tx_n, rx_q, rx_n;
  logic [1:0]       flat_q, flat_n, clat_q, clat_n;
  logic [GAP_W-1:0] gap_q, gap_n;
  logic             wr, wr_ctl, wr_misc, buf_hit;
  logic [ADDR_W-1:0] buf_off;

  always_comb begin
    wr      = reg_en & reg_we;
    wr_ctl  = wr && (reg_addr == OFS_CTRL);
    wr_misc = wr && (reg_addr == OFS_MISC);
    buf_off = reg_addr - OFS_BUF;
    buf_hit = (reg_addr >= OFS_BUF) && (buf_off < ADDR_W'(BUF_BYTES));
    host_we   = wr && buf_hit;
    host_widx = buf_off[IDX_W-1:2];
    host_ridx = buf_off[IDX_W-1:2];
    start_req = wr_ctl & reg_wdata[CTRL_EN] & reg_wdata[CTRL_GO];
    rdy_clr   = wr_ctl & ~reg_wdata[CTRL_EN];
    soft_rst  = wr_misc & reg_wdata[MISC_SRST];
  end

  // next-state for the software-visible fields
  always_comb begin
    en_n = en_q; tx_n = tx_q; rx_n = rx_q;
    flat_n = flat_q; clat_n = clat_q; gap_n = gap_q;
    if (wr_ctl) en_n = reg_wdata[CTRL_EN];
    if (wr && reg_addr == OFS_TXN) tx_n = reg_wdata[CNT_W-1:0];
    if (wr && reg_addr == OFS_RXN) rx_n = reg_wdata[CNT_W-1:0];
    if (wr_misc) begin
      flat_n = reg_wdata[MISC_FLAT +: 2];
      clat_n = reg_wdata[MISC_CLAT +: 2];
      gap_n  = reg_wdata[GAP_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; tx_q <= '0; rx_q <= '0;
      flat_q <= '0; clat_q <= '0; gap_q <= '0;
    end else begin
      en_q <= en_n; tx_q <= tx_n; rx_q <= rx_n;
      flat_q <= flat_n; clat_q <= clat_n; gap_q <= gap_n;
    end
  end

  assign tx_cnt  = tx_q;
  assign rx_cnt  = rx_q;
  assign gap_len = gap_q;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == OFS_CTRL) begin
      reg_rdata[CTRL_BUSY] = busy;
      reg_rdata[CTRL_RDY]  = ready;
      reg_rdata[CTRL_EN]   = en_q;
    end else if (reg_addr == OFS_TXN) begin
      reg_rdata[CNT_W-1:0] = tx_q;
    end else if (reg_addr == OFS_RXN) begin
      reg_rdata[CNT_W-1:0] = rx_q;
    end else if (reg_addr == OFS_MISC) begin
      reg_rdata[MISC_FLAT +: 2] = flat_q;
      reg_rdata[MISC_CLAT +: 2] = clat_q;
      reg_rdata[GAP_W-1:0]      = gap_q;
    end else if (reg_addr == OFS_STAT) begin
      reg_rdata[3:0] = state;
    end else if (buf_hit) begin
      reg_rdata = host_rdata;
    end
  end

  // R11: the control word never shows the start bit or the lane bit
  a_r11_ctrl_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == OFS_CTRL) |-> (reg_rdata[4] == 1'b0 && reg_rdata[CTRL_GO] == 1'b0));
endmodule

// File: rtl/spi_eng_seq.sv
module spi_eng_seq
  import spi_eng_pkg::*;
#(
  parameter int BUF_BYTES = 128,
  parameter int GAP_W = 5,
  localparam int IDX_W = $clog2(BUF_BYTES),
  localparam int CNT_W = IDX_W + 1,
  localparam int SUM_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             rdy_clr,
  input  logic             soft_rst,
  input  logic [CNT_W-1:0] tx_cnt,
  input  logic [CNT_W-1:0] rx_cnt,
  input  logic [GAP_W-1:0] gap_len,
  input  logic [7:0]       rbyte,
  input  logic             miso,
  output eng_state_e       state,
  output logic             busy,
  output logic             ready,
  output logic [IDX_W-1:0] eng_idx,
  output logic             eng_we,
  output logic [7:0]       eng_wbyte,
  output logic             sck,
  output logic             cs_n,
  output logic             mosi
);
  eng_state_e       st_q, st_n;
  logic             half_q, half_n, rdy_q, rdy_n;
  logic [2:0]       bit_q, bit_n;
  logic [CNT_W-1:0] idx_q, idx_n, tot_q, tot_n, txe_q, txe_n;
  logic [7:0]       sh_q, sh_n;
  logic [GAP_W-1:0] gap_q, gap_n;
  logic [SUM_W-1:0] sum_c;
  logic [CNT_W-1:0] tot_c, txe_c;
  logic             accept, shifting, byte_end;

  always_comb begin
    sum_c = {1'b0, tx_cnt} + {1'b0, rx_cnt};
    tot_c = (sum_c > SUM_W'(BUF_BYTES)) ? CNT_W'(BUF_BYTES) : sum_c[CNT_W-1:0];
    txe_c = (tx_cnt > CNT_W'(BUF_BYTES)) ? CNT_W'(BUF_BYTES) : tx_cnt;
    accept   = start_req && (st_q == ST_IDLE) && (gap_q == '0);
    shifting = (st_q == ST_SHIFT);
    byte_end = shifting && half_q && (bit_q == 3'd7);
  end

  always_comb begin
    st_n = st_q; half_n = half_q; bit_n = bit_q; idx_n = idx_q;
    tot_n = tot_q; txe_n = txe_q; sh_n = sh_q; rdy_n = rdy_q; gap_n = gap_q;
    if (soft_rst) begin
      st_n = ST_IDLE; rdy_n = 1'b0; gap_n = '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (gap_q != '0) gap_n = gap_q - 1'b1;
          if (accept) begin
            tot_n = tot_c; txe_n = txe_c; idx_n = '0;
            half_n = 1'b0; bit_n = 3'd0; rdy_n = 1'b0;
            if (tot_c == '0) begin
              st_n = ST_FINISH; rdy_n = 1'b1;
            end else begin
              st_n = ST_SHIFT;
            end
          end else if (rdy_clr) begin
            rdy_n = 1'b0;
          end
        end
        ST_SHIFT: begin
          half_n = ~half_q;
          if (half_q) begin
            sh_n  = {sh_q[6:0], miso};
            bit_n = bit_q + 3'd1;
            if (bit_q == 3'd7) begin
              idx_n = idx_q + 1'b1;
              if (idx_q == tot_q - 1'b1) begin
                st_n = ST_FINISH; rdy_n = 1'b1;
              end
            end
          end
        end
        ST_FINISH: begin
          st_n  = ST_IDLE;
          gap_n = gap_len;
        end
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; half_q <= 1'b0; bit_q <= '0; idx_q <= '0;
      tot_q <= '0; txe_q <= '0; sh_q <= '0; rdy_q <= 1'b0; gap_q <= '0;
    end else begin
      st_q <= st_n; half_q <= half_n; bit_q <= bit_n; idx_q <= idx_n;
      tot_q <= tot_n; txe_q <= txe_n; sh_q <= sh_n; rdy_q <= rdy_n; gap_q <= gap_n;
    end
  end

  always_comb begin
    state     = st_q;
    busy      = (st_q != ST_IDLE);
    ready     = rdy_q;
    eng_idx   = idx_q[IDX_W-1:0];
    eng_we    = byte_end && (idx_q >= txe_q);
    eng_wbyte = {sh_q[6:0], miso};
    sck       = shifting && half_q;
    cs_n      = !shifting;
    mosi      = shifting && (idx_q < txe_q) && rbyte[3'd7 - bit_q];
  end

  // R3: the serial clock only pulses inside the chip-select window
  a_r3_sck_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> !cs_n);
  // R4: data-out is quiet when chip-select is high
  a_r4_mosi_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !mosi);
  // R6: ready appears while the engine is still running
  a_r6_ready_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_q) |-> busy);
  // R6: running only drops with ready already up, unless soft reset forced it
  a_r6_busy_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (rdy_q || $past(soft_rst)));
  // R8: a transfer only starts once the quiet gap has run out
  a_r8_gap_respected: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(gap_q) == '0));
  // R10: soft reset lands the engine in idle with ready clear
  a_r10_soft_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (st_q == ST_IDLE && !rdy_q));
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_eng_pkg::*;
#(
  parameter int BUF_BYTES = 128,
  parameter int GAP_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              spi_sck,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int IDX_W  = $clog2(BUF_BYTES);
  localparam int CNT_W  = IDX_W + 1;
  localparam int WIDX_W = IDX_W - 2;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [CNT_W-1:0]  tx_cnt, rx_cnt;
  logic [GAP_W-1:0]  gap_len;
  logic              start_req, rdy_clr, soft_rst, busy, ready;
  eng_state_e        state;
  logic              host_we, eng_we;
  logic [WIDX_W-1:0] host_widx, host_ridx;
  logic [31:0]       host_rdata;
  logic [IDX_W-1:0]  eng_idx;
  logic [7:0]        eng_wbyte, eng_rbyte;

  spi_eng_regs #(.BUF_BYTES(BUF_BYTES), .GAP_W(GAP_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n),
    .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .gap_len(gap_len),
    .start_req(start_req), .rdy_clr(rdy_clr), .soft_rst(soft_rst),
    .busy(busy), .ready(ready), .state(state),
    .host_we(host_we), .host_widx(host_widx), .host_ridx(host_ridx),
    .host_rdata(host_rdata)
  );

  spi_eng_buf #(.BUF_BYTES(BUF_BYTES)) u_buf (
    .clk(clk),
    .host_we(host_we), .host_widx(host_widx), .host_wdata(reg_wdata),
    .host_ridx(host_ridx), .host_rdata(host_rdata),
    .eng_we(eng_we), .eng_idx(eng_idx), .eng_wbyte(eng_wbyte),
    .eng_rbyte(eng_rbyte)
  );

  spi_eng_seq #(.BUF_BYTES(BUF_BYTES), .GAP_W(GAP_W)) u_seq (
    .clk(clk), .rst_n(rst_int_n),
    .start_req(start_req), .rdy_clr(rdy_clr), .soft_rst(soft_rst),
    .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .gap_len(gap_len),
    .rbyte(eng_rbyte), .miso(spi_miso),
    .state(state), .busy(busy), .ready(ready),
    .eng_idx(eng_idx), .eng_we(eng_we), .eng_wbyte(eng_wbyte),
    .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi)
  );
endmodule

// File: tb/sim_spi_cmd_engine.sv
`timescale 1ns/1ps
module sim_spi_cmd_engine;
  localparam int NB = 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_en = 1'b0, reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        spi_sck, spi_cs_n, spi_mosi;
  logic        spi_miso = 1'b0;

  always #2.5 clk = ~clk;

  spi_cmd_engine u0 (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  int n_chk = 0, n_bad = 0, cycles = 0;
  logic done_flag = 1'b0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] rxpat(input int k);
    return 8'(k * 37 + 8'h6B);
  endfunction

  // ---------------- behavioural reference model ----------------
  logic [7:0] img [NB];
  int m_left = 0, m_fin = 0, m_gap = 0, m_ready = 0, m_en = 0;
  int m_out = 0, m_in = 0, m_tot = 0, m_oute = 0, m_desel = 0, m_started = 0;

  function automatic bit mbusy();
    return (m_left > 0) || (m_fin != 0);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_left = 0; m_fin = 0; m_gap = 0; m_ready = 0; m_en = 0;
      m_out = 0; m_in = 0; m_desel = 0; m_tot = 0; m_oute = 0;
    end else begin
      int pos_old, gap_old;
      bit wr, srst;
      wr = reg_en && reg_we;
      srst = wr && reg_addr == 12'h538 && reg_wdata[28];
      pos_old = 16 * m_tot - m_left;
      gap_old = m_gap;
      if (srst) begin
        m_left = 0; m_fin = 0; m_gap = 0; m_ready = 0;
      end else if (m_left > 0) begin
        if ((pos_old % 16) == 15 && (pos_old / 16) >= m_oute)
          img[pos_old / 16] = rxpat(pos_old / 16 - m_oute);
        m_left--;
        if (m_left == 0) begin m_fin = 1; m_ready = 1; end
      end else if (m_fin != 0) begin
        m_fin = 0; m_gap = m_desel;
      end else begin
        if (m_gap > 0) m_gap--;
        if (wr && reg_addr == 12'h500 && reg_wdata[3] && reg_wdata[2] && gap_old == 0) begin
          m_tot  = (m_out + m_in > NB) ? NB : m_out + m_in;
          m_oute = (m_out > NB) ? NB : m_out;
          m_ready = 0; m_started++;
          if (m_tot == 0) begin m_fin = 1; m_ready = 1; end
          else m_left = 16 * m_tot;
        end else if (wr && reg_addr == 12'h500 && !reg_wdata[3]) begin
          m_ready = 0;
        end
      end
      if (wr && reg_addr == 12'h500) m_en = reg_wdata[3];
      if (wr && reg_addr == 12'h504) m_out = reg_wdata[7:0];
      if (wr && reg_addr == 12'h508) m_in = reg_wdata[7:0];
      if (wr && reg_addr == 12'h538) m_desel = reg_wdata[4:0];
      if (wr && reg_addr >= 12'h800 && reg_addr < 12'h880)
        for (int b = 0; b < 4; b++) img[(reg_addr - 12'h800) / 4 * 4 + b] = reg_wdata[8*b +: 8];
    end
  end

  // per-clock comparison of the serial pins, and slave data drive (R3, R4, R5)
  always @(negedge clk) begin
    if (rst_n && cycles > 4 && !done_flag) begin
      int pos, k, b;
      logic e_cs, e_sck, e_mosi;
      pos = 16 * m_tot - m_left;
      k = pos / 16; b = (pos % 16) / 2;
      e_cs = !(m_left > 0);
      e_sck = (m_left > 0) && (pos % 2 == 1);
      e_mosi = (m_left > 0) && (k < m_oute) ? img[k][7 - b] : 1'b0;
      chk(spi_cs_n == e_cs && spi_sck == e_sck && spi_mosi == e_mosi,
          "R3/R4 pins", {spi_cs_n, spi_sck, spi_mosi}, {e_cs, e_sck, e_mosi});
      if (m_left > 0 && k >= m_oute) spi_miso = rxpat(k - m_oute) >> (7 - b);
      else spi_miso = 1'b0;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done_flag) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end

  // ---------------- register access ----------------
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // poll until idle; compare running/ready to the model on each read
  task automatic wait_idle(input bit expect_two_step);
    logic [31:0] c;
    bit seen_both = 0;
    for (int i = 0; i < 4000; i++) begin
      rd(12'h500, c);
      chk(c[0] == mbusy() && c[1] == m_ready[0], "R11 ctrl flags",
          c[1:0], {m_ready[0], mbusy()});
      if (c[0] && c[1]) seen_both = 1;
      if (!c[0]) break;
    end
    if (expect_two_step) chk(seen_both, "R6 ready-before-idle", seen_both, 1);
    chk(c[1] == 1'b1, "R6 ready held", c[1], 1);
  endtask

  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(12'h500, d); chk(d == 0, "R1 ctrl", d, 0);
    rd(12'h504, d); chk(d == 0, "R1 txcount", d, 0);
    rd(12'h538, d); chk(d == 0, "R1 misc", d, 0);
    rd(12'h550, d); chk(d == 0, "R1 state", d, 0);
    chk(spi_cs_n && !spi_sck && !spi_mosi, "R1 pins", {spi_cs_n, spi_sck, spi_mosi}, 3'b100);

    // R2 buffer fill and readback
    for (int w = 0; w < 32; w++) wr(12'h800 + 12'(4*w), 32'h03020100 + 32'(w) * 32'h04040404);
    wr(12'h800, 32'h5AC3_9601);
    rd(12'h800, d); chk(d == 32'h5AC3_9601, "R2 word0", d, 32'h5AC3_9601);
    rd(12'h814, d); chk(d == 32'h17161514, "R2 word5", d, 32'h17161514);

    // R13 misc fields, R11 reserved control bits
    wr(12'h538, (32'd2 << 25) | (32'd1 << 8) | 32'd3);
    rd(12'h538, d); chk(d == 32'h0400_0103, "R13 misc readback", d, 32'h0400_0103);
    wr(12'h500, 32'h18);
    rd(12'h500, d); chk(d == 32'h08, "R11 lane bit reads 0", d, 32'h08);
    wr(12'h500, 32'h0);

    // main transfer: 4 out, 3 in (R3 R4 R5 R6 R12)
    wr(12'h504, 4); wr(12'h508, 3);
    wr(12'h500, 32'h0C);
    rd(12'h550, d); chk(d == 2, "R12 state shifting", d, 2);
    rd(12'h500, d); chk(d == 32'h9, "R11 running", d, 32'h9);
    wr(12'h500, 32'h0C);  // ignored while running (R7)
    rd(12'h550, d); chk(d == 2, "R7 start while running ignored", d, 2);
    wait_idle(1);
    chk(m_started == 1, "R7 single start", m_started, 1);
    rd(12'h800, d); chk(d == 32'h5AC3_9601, "R5 tx bytes kept", d, 32'h5AC3_9601);
    rd(12'h804, d);
    chk(d == {8'h07, rxpat(2), rxpat(1), rxpat(0)}, "R5 rx placement", d,
        {8'h07, rxpat(2), rxpat(1), rxpat(0)});
    rd(12'h550, d); chk(d == 0, "R12 state idle", d, 0);

    // quiet gap (R7 R8)
    wr(12'h538, 32'd10);
    wr(12'h504, 2); wr(12'h508, 0);
    wr(12'h500, 32'h0C);
    wait_idle(1);
    wr(12'h500, 32'h0C);
    rd(12'h500, d); chk(d[0] == 1'b0 && spi_cs_n, "R8 start refused in gap", d[0], 0);
    repeat (12) @(negedge clk);
    wr(12'h500, 32'h0C);
    rd(12'h500, d); chk(d[0] == 1'b1, "R8 start after gap", d[0], 1);
    wait_idle(1);
    wr(12'h500, 32'h0);
    rd(12'h500, d); chk(d[1] == 1'b0, "R6 ready cleared by write", d[1], 0);
    wr(12'h538, 32'd0);

    // zero-length transfer (R13)
    wr(12'h504, 0); wr(12'h508, 0);
    wr(12'h500, 32'h0C);
    wait_idle(0);
    chk(spi_cs_n, "R13 zero length keeps cs high", spi_cs_n, 1);

    // clamp (R9)
    wr(12'h504, 126); wr(12'h508, 5);
    wr(12'h500, 32'h0C);
    wait_idle(1);
    rd(12'h87C, d);
    chk(d[31:16] == {rxpat(1), rxpat(0)}, "R9 last bytes", d[31:16], {rxpat(1), rxpat(0)});
    rd(12'h800, d); chk(d == 32'h5AC3_9601, "R9 no wrap to byte0", d, 32'h5AC3_9601);

    // soft reset mid-transfer (R10)
    wr(12'h504, 2); wr(12'h508, 2);
    wr(12'h500, 32'h0C);
    repeat (5) @(negedge clk);
    wr(12'h538, (32'd1 << 28) | (32'd2 << 25) | (32'd1 << 8) | 32'd4);
    chk(spi_cs_n, "R10 cs high", spi_cs_n, 1);
    rd(12'h500, d); chk(d[1:0] == 2'b00, "R10 flags clear", d[1:0], 0);
    rd(12'h550, d); chk(d == 0, "R10 state idle", d, 0);
    rd(12'h538, d); chk(d == 32'h0400_0104, "R10 bit28 reads 0", d, 32'h0400_0104);

    repeat (4) @(negedge clk);
    done_flag = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule